// File: doc/BRIEF.md
# Register Ring Station

This block is one station on a narrow serial register ring. Each packet on the ring takes three consecutive beats. The first beat carries a command code, a source tag and a register address. The second and third beats carry the upper and lower halves of a data word that is twice the ring width. The station forwards every packet it sees, unchanged, to the next station.

When a read or write request targets the station's own register window, the station also serves the request and sends back a response packet with a rewritten command. The response always leaves directly behind the request that caused it. Commands the station does not serve, and requests to foreign addresses, are only passed along.

The receiver captures ring beats on the falling clock edge, and the transmitter launches beats on the rising edge. Outgoing packets wait in a small queue. After every packet the transmitter sends one all-zero beat. If the queue is full, an incoming packet is dropped and a sticky overflow flag is raised.

Top module: `ring_station`

## Requirements
- R1: Beat one holds the command in bits [15:13], the source tag in bits [12:10] and the address in bits [9:0]. Beat two holds data[31:16] and beat three holds data[15:0]. A packet starts only on a beat whose command field is nonzero while the receiver is between packets. Beats with a zero command field are idle, whatever their other bits hold.
- R2: Every received packet is sent out unchanged, in arrival order. It always leaves ahead of any response it causes.
- R3: Command codes are 1 = write request, 2 = read request, 3 = read response and 4 = write response. The local window is addresses 0x040 to 0x047, which select registers 0 to 7.
- R4: A write request to a local address other than 0x040 stores the data. It is followed by a write response (code 4) with the same tag and address, carrying the register contents after the write.
- R5: A read request to a local address is followed by a read response (code 3) with the same tag and address, carrying that register's contents.
- R6: Register 0 (address 0x040) is read-only and holds 0x5EED0001. Writing to it changes nothing, and its write response carries 0x5EED0001.
- R7: Requests to addresses outside the window, and commands 3 to 7 at any address, are forwarded without a response.
- R8: Each outgoing packet is followed by at least one all-zero beat. The output is zero whenever nothing is queued.
- R9: Input beats are captured on the falling edge, and the output changes on the rising edge. With the transmitter idle, a forwarded packet's first beat appears on the rising edge right after the falling edge that captured its third beat. A response's first beat follows exactly four cycles later.
- R10: The queue holds four packets. A packet arriving while the queue is full is dropped, and `overflow` is set and stays set until reset.
- R11: During reset the output is zero and `overflow` is clear. After reset, registers 1 to 7 read zero and register 0 reads 0x5EED0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; input captured on the falling edge, output launched on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ringIn | input | 16 | Ring beats from the upstream station |
| ringOut | output | 16 | Ring beats to the downstream station |
| overflow | output | 1 | Sticky flag: a packet was dropped because the queue was full |

## Verification
A forwarded packet's first beat is due one cycle after the falling edge that captured its last input beat. Its response's first beat is due four cycles after that, and the zero beat is due on the fourth beat of every packet. The directed latency checks sample `ringOut` on the falling edge at exactly those counts. A scoreboard monitor, also sampling on the falling edge, checks the order and contents of all remaining packets and the zero beat that follows each one. The overflow check counts queue occupancy against back-to-back requests, and drains the queue before the flag and the register contents are inspected after reset.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_IDLE  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_WRREQ = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RDREQ = 3'd2;
  localparam logic [CMD_W-1:0] CMD_RDRSP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WRRSP = 3'd4;

  // receive-side strobes, acted on at the falling edge
  typedef struct packed {
    logic capHdr;
    logic capHi;
    logic pushOrig;
    logic pushResp;
  } rxStrobe_t;

  // transmit-side strobes, acted on at the rising edge
  typedef struct packed {
    logic loadHdr;
    logic loadHi;
    logic loadLo;
    logic drvIdle;
  } txStrobe_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdNz,
  input  logic      qEmpty,
  output rxStrobe_t rxStb,
  output txStrobe_t txStb
);
  logic [1:0] rxCnt;
  logic       respStage;
  logic [1:0] txCnt;

  always_comb begin
    rxStb.capHdr   = (rxCnt == 2'd0) && cmdNz;
    rxStb.capHi    = (rxCnt == 2'd1);
    rxStb.pushOrig = (rxCnt == 2'd2);
    rxStb.pushResp = respStage;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt     <= 2'd0;
      respStage <= 1'b0;
    end else begin
      respStage <= rxStb.pushOrig;
      case (rxCnt)
        2'd0:    rxCnt <= cmdNz ? 2'd1 : 2'd0;
        2'd1:    rxCnt <= 2'd2;
        default: rxCnt <= 2'd0;
      endcase
    end
  end

  always_comb begin
    txStb.loadHdr = (txCnt == 2'd0) && !qEmpty;
    txStb.loadHi  = (txCnt == 2'd1);
    txStb.loadLo  = (txCnt == 2'd2);
    txStb.drvIdle = (txCnt == 2'd3) || ((txCnt == 2'd0) && qEmpty);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txCnt <= 2'd0;
    else begin
      case (txCnt)
        2'd0:    txCnt <= qEmpty ? 2'd0 : 2'd1;
        2'd1:    txCnt <= 2'd2;
        2'd2:    txCnt <= 2'd3;
        default: txCnt <= 2'd0;
      endcase
    end
  end

  // R1: beats of one packet are taken in order
  a_r1_hi_after_hdr: assert property (@(negedge clk) disable iff (!rstN)
    rxStb.capHi |-> $past(rxStb.capHdr));
  a_r1_lo_after_hi: assert property (@(negedge clk) disable iff (!rstN)
    rxStb.pushOrig |-> $past(rxStb.capHi));
  // R2: a response push only ever follows the push of its request
  a_r2_resp_after_orig: assert property (@(negedge clk) disable iff (!rstN)
    rxStb.pushResp |-> $past(rxStb.pushOrig));
  // R8: the gap beat never starts a packet
  a_r8_gap_beat: assert property (@(posedge clk) disable iff (!rstN)
    (txCnt == 2'd3) |-> (txStb.drvIdle && !txStb.loadHdr));
endmodule

// File: rtl/ring_pktq.sv
module ring_pktq #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         empty,
  output logic         overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] DEPTH_P = (PTR_W+1)'(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [PTR_W:0] wrPtr;
  logic [PTR_W:0] rdPtr;
  logic           full;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                 (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign headData = mem[rdPtr[PTR_W-1:0]];

  always_ff @(negedge clk) begin
    if (push && !full) mem[wrPtr[PTR_W-1:0]] <= pushData;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      overflow <= 1'b0;
    end else if (push) begin
      if (full) overflow <= 1'b1;
      else      wrPtr    <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdPtr <= '0;
    else if (pop && !empty) rdPtr <= rdPtr + 1'b1;
  end

  // R10: occupancy never exceeds the depth
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= DEPTH_P);
  // R10: the overflow flag is sticky
  a_r10_sticky: assert property (@(negedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

// File: rtl/ring_regfile.sv
module ring_regfile #(
  parameter int              DATA_W   = 32,
  parameter int              NREGS    = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5EED0001
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        wbData
);
  localparam int IDX_W = $clog2(NREGS);

  logic [DATA_W-1:0] store [NREGS];

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) store[i] <= (i == 0) ? ID_VALUE : '0;
    end else if (we && (idx != '0)) begin
      store[idx] <= wdata;
    end
  end

  assign rdata  = store[idx];
  assign wbData = (idx == IDX_W'(0)) ? store[0] : wdata;

  // R6: the identity register keeps its value
  a_r6_id_kept: assert property (@(negedge clk) disable iff (!rstN)
    store[0] == ID_VALUE);
endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_pkg::*;
#(
  parameter int RING_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int WIN_BASE = 'h040,
  parameter int WIN_REGS = 8,
  parameter int QDEPTH   = 4,
  parameter logic [2*RING_W-1:0] ID_VALUE = 32'h5EED0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RING_W-1:0] ringIn,
  input  rxStrobe_t         rxStb,
  input  txStrobe_t         txStb,
  output logic [RING_W-1:0] ringOut,
  output logic              qEmpty,
  output logic              overflow,
  output logic              cmdNz
);
  localparam int DATA_W = 2 * RING_W;
  localparam int PKT_W  = 3 * RING_W;
  localparam int IDX_W  = $clog2(WIN_REGS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WIN_REGS);

  logic [RING_W-1:0] hdrQ, hiQ;
  logic [CMD_W-1:0]  hdrCmd;
  logic [ADDR_W-1:0] hdrAddr, offset;
  logic              isLocal, isWr, isRd;
  logic [DATA_W-1:0] rdata, wbData, respData;
  logic [PKT_W-1:0]  respQ, qData, headData;
  logic              respValid, qPush;

  assign cmdNz   = ringIn[RING_W-1 -: CMD_W] != CMD_IDLE;
  assign hdrCmd  = hdrQ[RING_W-1 -: CMD_W];
  assign hdrAddr = hdrQ[ADDR_W-1:0];
  assign offset  = hdrAddr - BASE_A;
  assign isLocal = (hdrAddr >= BASE_A) && (offset < SPAN_A);
  assign isWr    = hdrCmd == CMD_WRREQ;
  assign isRd    = hdrCmd == CMD_RDREQ;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrQ <= '0;
      hiQ  <= '0;
    end else begin
      if (rxStb.capHdr) hdrQ <= ringIn;
      if (rxStb.capHi)  hiQ  <= ringIn;
    end
  end

  ring_regfile #(.DATA_W(DATA_W), .NREGS(WIN_REGS), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rstN(rstN),
    .we(rxStb.pushOrig && isLocal && isWr),
    .idx(offset[IDX_W-1:0]),
    .wdata({hiQ, ringIn}),
    .rdata(rdata), .wbData(wbData)
  );

  assign respData = isWr ? wbData : rdata;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      respQ     <= '0;
      respValid <= 1'b0;
    end else if (rxStb.pushOrig) begin
      respQ     <= {(isWr ? CMD_WRRSP : CMD_RDRSP), hdrQ[RING_W-CMD_W-1:0], respData};
      respValid <= isLocal && (isWr || isRd);
    end
  end

  assign qPush = rxStb.pushOrig || (rxStb.pushResp && respValid);
  assign qData = rxStb.pushOrig ? {hdrQ, hiQ, ringIn} : respQ;

  ring_pktq #(.W(PKT_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rstN(rstN), .push(qPush), .pushData(qData),
    .pop(txStb.loadLo), .headData(headData), .empty(qEmpty), .overflow(overflow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ringOut <= '0;
    else if (txStb.loadHdr) ringOut <= headData[PKT_W-1 -: RING_W];
    else if (txStb.loadHi)  ringOut <= headData[DATA_W-1 -: RING_W];
    else if (txStb.loadLo)  ringOut <= headData[RING_W-1:0];
    else                    ringOut <= '0;
  end

  // R11: output held at zero through reset
  a_r11_reset_out: assert property (@(negedge clk)
    !rstN |-> (ringOut == '0));
  // R7: unsupported commands never arm a response
  a_r7_no_resp: assert property (@(negedge clk) disable iff (!rstN)
    (rxStb.pushOrig && !isWr && !isRd) |=> !respValid);
endmodule

// File: rtl/ring_station.sv
module ring_station #(
  parameter int RING_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int WIN_BASE = 'h040,
  parameter int WIN_REGS = 8,
  parameter int QDEPTH   = 4,
  parameter logic [2*RING_W-1:0] ID_VALUE = 32'h5EED0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RING_W-1:0] ringIn,
  output logic [RING_W-1:0] ringOut,
  output logic              overflow
);
  import ring_pkg::*;

  rxStrobe_t rxStb;
  txStrobe_t txStb;
  logic      cmdNz, qEmpty;

  ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdNz(cmdNz), .qEmpty(qEmpty),
    .rxStb(rxStb), .txStb(txStb)
  );

  ring_datapath #(
    .RING_W(RING_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
    .WIN_REGS(WIN_REGS), .QDEPTH(QDEPTH), .ID_VALUE(ID_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ringIn(ringIn), .rxStb(rxStb), .txStb(txStb),
    .ringOut(ringOut), .qEmpty(qEmpty), .overflow(overflow), .cmdNz(cmdNz)
  );
endmodule

// File: tb/sim_ring_station.sv
module sim_ring_station;
  localparam int RW = 16;
  localparam logic [31:0] IDV = 32'h5EED0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [RW-1:0] ringIn = '0;
  logic [RW-1:0] ringOut;
  logic overflow;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b1;
  bit done = 1'b0;

  logic [47:0] expQ[$];
  string       tagQ[$];
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  ring_station #(.ID_VALUE(IDV)) u0 (
    .clk(clk), .rstN(rstN), .ringIn(ringIn), .ringOut(ringOut), .overflow(overflow)
  );

  task automatic check(input bit ok, input string rq, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic initModel();
    for (int i = 0; i < 8; i++) mdl[i] = (i == 0) ? IDV : 32'h0;
  endtask

  // driver: three beats, plus expected items for the scoreboard
  task automatic sendPkt(input logic [2:0] cmd, input logic [2:0] tag, input logic [9:0] addr,
                         input logic [31:0] data, input string rq, input bit chain);
    logic [31:0] rd;
    int idx;
    @(posedge clk) #1 ringIn = {cmd, tag, addr};
    @(posedge clk) #1 ringIn = data[31:16];
    @(posedge clk) #1 ringIn = data[15:0];
    expQ.push_back({cmd, tag, addr, data});
    tagQ.push_back(rq);
    if (addr >= 10'h040 && addr <= 10'h047 && (cmd == 3'd1 || cmd == 3'd2)) begin
      idx = int'(addr) - 'h40;
      if (cmd == 3'd1 && idx != 0) mdl[idx] = data;
      rd = mdl[idx];
      expQ.push_back({(cmd == 3'd1) ? 3'd4 : 3'd3, tag, addr, rd});
      tagQ.push_back(idx == 0 ? "R6" : (cmd == 3'd1 ? "R4" : "R5"));
    end
    if (!chain) begin
      @(posedge clk) #1 ringIn = '0;
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // monitor: collects packets on the falling edge and compares in order
  int mCnt = 0;
  logic [47:0] got;
  always @(negedge clk) begin
    if (!rstN || !monOn) mCnt = 0;
    else begin
      case (mCnt)
        0: if (ringOut[15:13] != 3'd0) begin got[47:32] = ringOut; mCnt = 1; end
        1: begin got[31:16] = ringOut; mCnt = 2; end
        2: begin
          got[15:0] = ringOut;
          mCnt = 3;
          if (expQ.size() == 0) check(1'b0, "R7 unexpected packet", got, 48'h0);
          else begin
            logic [47:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(got === e, {t, " R2 packet"}, got, e);
          end
        end
        default: begin
          check(ringOut === '0, "R8 gap beat", {32'h0, ringOut}, 48'h0);
          mCnt = 0;
        end
      endcase
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    initModel();
    repeat (3) @(negedge clk);
    check(ringOut === '0, "R11 reset output", {32'h0, ringOut}, 48'h0);
    check(overflow === 1'b0, "R11 reset overflow", {47'h0, overflow}, 48'h0);
    @(posedge clk) #1 rstN = 1'b1;
    repeat (3) @(posedge clk);

    // R9: forwarded header one cycle after the last beat is captured
    sendPkt(3'd2, 3'd5, 10'h100, 32'h12345678, "R7", 1'b0);
    @(negedge clk);
    check(ringOut === {3'd2, 3'd5, 10'h100}, "R9 forward latency", {32'h0, ringOut}, {32'h0, 3'd2, 3'd5, 10'h100});
    drain();

    // R9/R5: local read, response four cycles after the request header
    sendPkt(3'd2, 3'd1, 10'h042, 32'hDEADBEEF, "R2", 1'b0);
    @(negedge clk);
    check(ringOut === {3'd2, 3'd1, 10'h042}, "R9 request header", {32'h0, ringOut}, {32'h0, 3'd2, 3'd1, 10'h042});
    repeat (4) @(negedge clk);
    check(ringOut === {3'd3, 3'd1, 10'h042}, "R9 response header", {32'h0, ringOut}, {32'h0, 3'd3, 3'd1, 10'h042});
    drain();

    // R4/R5: write then read back-to-back
    sendPkt(3'd1, 3'd2, 10'h043, 32'hCAFEF00D, "R2", 1'b1);
    sendPkt(3'd2, 3'd3, 10'h043, 32'h0, "R2", 1'b0);
    drain();

    // R6: identity register is read-only
    sendPkt(3'd1, 3'd4, 10'h040, 32'h11112222, "R2", 1'b1);
    sendPkt(3'd2, 3'd4, 10'h040, 32'h0, "R2", 1'b0);
    drain();

    // R7: unsupported commands and window edges
    sendPkt(3'd5, 3'd0, 10'h041, 32'hAAAA5555, "R7", 1'b1);
    sendPkt(3'd3, 3'd1, 10'h044, 32'h01020304, "R7", 1'b1);
    sendPkt(3'd4, 3'd2, 10'h045, 32'h0A0B0C0D, "R7", 1'b0);
    drain();
    sendPkt(3'd1, 3'd6, 10'h047, 32'h76543210, "R3", 1'b1);
    sendPkt(3'd1, 3'd6, 10'h048, 32'hFFFF0000, "R7", 1'b1);
    sendPkt(3'd1, 3'd6, 10'h03F, 32'h0000FFFF, "R7", 1'b1);
    sendPkt(3'd2, 3'd7, 10'h047, 32'h0, "R3", 1'b0);
    drain();

    // R1: zero-command beats with other bits set are idle
    for (int i = 0; i < 6; i++) @(posedge clk) #1 ringIn = 16'h1FFF;
    @(posedge clk) #1 ringIn = '0;
    repeat (12) @(negedge clk);
    check(expQ.size() == 0 && ringOut === '0, "R1 idle beats", {32'h0, ringOut}, 48'h0);
    check(overflow === 1'b0, "R10 no overflow yet", {47'h0, overflow}, 48'h0);

    // R10: overflow under back-to-back local reads
    monOn = 1'b0;
    for (int i = 0; i < 6; i++) sendPkt(3'd2, 3'd1, 10'h041, 32'h0, "R10", 1'b1);
    @(posedge clk) #1 ringIn = '0;
    repeat (60) @(negedge clk);
    check(overflow === 1'b1, "R10 overflow set", {47'h0, overflow}, 48'h1);
    repeat (10) @(negedge clk);
    check(overflow === 1'b1, "R10 overflow sticky", {47'h0, overflow}, 48'h1);
    check(ringOut === '0, "R8 idle when empty", {32'h0, ringOut}, 48'h0);

    // R11: reset restores output, flag and registers
    @(posedge clk) #1 rstN = 1'b0;
    @(negedge clk);
    check(ringOut === '0 && overflow === 1'b0, "R11 second reset", {31'h0, overflow, ringOut}, 48'h0);
    expQ.delete();
    tagQ.delete();
    initModel();
    @(posedge clk) #1 rstN = 1'b1;
    monOn = 1'b1;
    sendPkt(3'd2, 3'd2, 10'h043, 32'h0, "R11", 1'b1);
    sendPkt(3'd2, 3'd2, 10'h040, 32'h0, "R11", 1'b0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule